// File: doc/BRIEF.md
# Serial Port Register Block

This block is the bus-facing register file of a serial port. A host reaches it through a 64-byte window with byte-wide data. Inside the window are two mode registers, a status register, an interrupt status register and its mask, two fixed baud divisor bytes, a transmit holding byte and a command register. Bit-level shifting, baud timing and parity are handled elsewhere. The block connects to a receive FIFO through occupancy flags, a data byte, a pop strobe and a flush strobe. It connects to a transmit serializer through a byte plus a one-cycle send strobe.

The two mode registers share one offset. A 1-bit pointer selects which of them an access reaches. Each write moves the pointer to the second register, and a command moves it back to the first. A command byte carries three independent fields, applied in this order: a misc action, a transmitter action and a receiver action. A single level interrupt line is high whenever any masked interrupt status bit is set. The receive interrupt source is chosen by a mode bit: either FIFO full or data ready.

Bus accesses take one cycle. A strobe is qualified by a write flag, and read data appears on the cycle after the strobe.

Top module: `uart_regblock`

## Requirements
- R1: After reset, status reads 0x08 (only bit 3 set), interrupt status reads 0x00, both mode registers read 0x00, the mode pointer selects the first register, the interrupt line is low and no strobe is active.
- R2: Offset 0x00 reads and writes the mode register chosen by the pointer. Every write to 0x00 sets the pointer to the second register, reads leave the pointer unchanged, and a misc command value of 1 returns the pointer to the first register.
- R3: Status at offset 0x04 reads {4'b0, tx_empty, tx_enabled, rx_full_i, rx_nonempty_i}, with bit 0 the LSB. Writes to 0x04 change nothing.
- R4: A write to 0x0C latches the byte. If the transmitter is enabled, the byte comes out on tx_byte_o with tx_send_o high for one cycle, and tx_empty stays 1. Otherwise tx_empty clears and there is no strobe, and a later enable command sends the held byte and sets tx_empty.
- R5: In the command byte at 0x08, bits [3:2] control the transmitter and bits [1:0] control the receiver. In each field, 1 enables, 2 disables, and 0 and 3 change nothing. rx_enable_o shows the receiver enable, and status bit 2 shows the transmitter enable.
- R6: Command bits [6:4] are the misc field. Value 2 disables the receiver and pulses rx_flush_o for one cycle. Value 3 disables the transmitter and sets tx_empty, dropping any held byte without a send strobe.
- R7: Interrupt status at 0x14 reads {1'b0, 4'b0, brk, rx_int, tx_int}. tx_int equals the transmitter enable. rx_int equals rx_full_i when bit 6 of the first mode register is 1, and rx_nonempty_i when that bit is 0. irq_o is high exactly when the AND of interrupt status and mask is nonzero.
- R8: A one-cycle high on break_i sets the brk bit, which holds until a misc command value of 5 clears it.
- R9: A read of 0x0C returns rx_data_i and pulses rx_pop_o for one cycle when rx_nonempty_i is high. When rx_nonempty_i is low, the read returns 0x00 with no pop.
- R10: Offsets 0x18 and 0x1C read the high and low baud divisor parameters. Every other offset not named above reads 0x00, and read data is 0x00 on cycles without a read.
- R11: A write to 0x14 loads the mask. A read of 0x14 returns interrupt status, never the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 6 | Byte offset in the window |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Level interrupt request |
| tx_send_o | output | 1 | One-cycle strobe: tx_byte_o is valid for the serializer |
| tx_byte_o | output | 8 | Byte handed to the serializer |
| rx_nonempty_i | input | 1 | Receive FIFO holds at least one byte |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_data_i | input | 8 | Head byte of the receive FIFO |
| rx_pop_o | output | 1 | One-cycle pop of the receive FIFO head |
| rx_flush_o | output | 1 | One-cycle flush of the receive FIFO |
| rx_enable_o | output | 1 | Receiver enable |
| break_i | input | 1 | Break-change indication, one cycle per event |

## Verification
The assertions assume at most one bus access per cycle. They also assume the FIFO flags are consistent: rx_full_i is never high while rx_nonempty_i is low. The bench drives every access as a single-cycle strobe and only applies flag pairs that keep full implying non-empty. It also holds break_i low except during the dedicated break test, so interrupt status sweeps see brk at a known value.

// File: rtl/uart_regblock.sv
module uart_regblock #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [7:0] BAUD_HI = 8'h00,
  parameter logic [7:0] BAUD_LO = 8'h1A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          tx_send_o,
  output logic [DW-1:0] tx_byte_o,
  input  logic          rx_nonempty_i,
  input  logic          rx_full_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_pop_o,
  output logic          rx_flush_o,
  output logic          rx_enable_o,
  input  logic          break_i
);

  localparam logic [AW-1:0] OFF_MODE = AW'(6'h00);
  localparam logic [AW-1:0] OFF_STAT = AW'(6'h04);
  localparam logic [AW-1:0] OFF_CMD  = AW'(6'h08);
  localparam logic [AW-1:0] OFF_DATA = AW'(6'h0C);
  localparam logic [AW-1:0] OFF_INT  = AW'(6'h14);
  localparam logic [AW-1:0] OFF_BDH  = AW'(6'h18);
  localparam logic [AW-1:0] OFF_BDL  = AW'(6'h1C);
  localparam int RXSEL_BIT = 6;

  logic [DW-1:0] mode0, mode1, hold, imr;
  logic          ptr, tx_en, tx_empty, rx_en, brk;

  logic [DW-1:0] n_mode0, n_mode1, n_hold, n_imr;
  logic          n_ptr, n_tx_en, n_tx_empty, n_rx_en, n_brk;
  logic          send, flush;

  logic          wr, rd;
  logic [DW-1:0] status, isr, rmux;
  logic          rx_int;
  logic [2:0]    misc;
  logic [1:0]    txf, rxf;

  assign wr   = bus_sel_i &  bus_we_i;
  assign rd   = bus_sel_i & ~bus_we_i;
  assign misc = bus_wdata_i[6:4];
  assign txf  = bus_wdata_i[3:2];
  assign rxf  = bus_wdata_i[1:0];

  assign status = {4'b0, tx_empty, tx_en, rx_full_i, rx_nonempty_i};
  assign rx_int = mode0[RXSEL_BIT] ? rx_full_i : rx_nonempty_i;
  assign isr    = {1'b0, 4'b0, brk, rx_int, tx_en};
  assign irq_o  = |(isr & imr);
  assign rx_enable_o = rx_en;

  always_comb begin
    n_mode0    = mode0;
    n_mode1    = mode1;
    n_ptr      = ptr;
    n_hold     = hold;
    n_imr      = imr;
    n_tx_en    = tx_en;
    n_tx_empty = tx_empty;
    n_rx_en    = rx_en;
    n_brk      = brk;
    send       = 1'b0;
    flush      = 1'b0;
    if (wr) begin
      case (bus_addr_i)
        OFF_MODE: begin
          if (ptr) n_mode1 = bus_wdata_i;
          else     n_mode0 = bus_wdata_i;
          n_ptr = 1'b1;
        end
        OFF_CMD: begin
          case (misc)
            3'd1: n_ptr = 1'b0;
            3'd2: begin
              n_rx_en = 1'b0;
              flush   = 1'b1;
            end
            3'd3: begin
              n_tx_en    = 1'b0;
              n_tx_empty = 1'b1;
            end
            3'd5: n_brk = 1'b0;
            default: ;
          endcase
          case (txf)
            2'd1: n_tx_en = 1'b1;
            2'd2: n_tx_en = 1'b0;
            default: ;
          endcase
          if ((txf == 2'd1 || txf == 2'd2) && n_tx_en && !n_tx_empty) begin
            send       = 1'b1;
            n_tx_empty = 1'b1;
          end
          case (rxf)
            2'd1: n_rx_en = 1'b1;
            2'd2: n_rx_en = 1'b0;
            default: ;
          endcase
        end
        OFF_DATA: begin
          n_hold = bus_wdata_i;
          if (tx_en) begin
            send       = 1'b1;
            n_tx_empty = 1'b1;
          end else begin
            n_tx_empty = 1'b0;
          end
        end
        OFF_INT: n_imr = bus_wdata_i;
        default: ;
      endcase
    end
    if (break_i) n_brk = 1'b1;
  end

  always_comb begin
    case (bus_addr_i)
      OFF_MODE: rmux = ptr ? mode1 : mode0;
      OFF_STAT: rmux = status;
      OFF_DATA: rmux = rx_nonempty_i ? rx_data_i : '0;
      OFF_INT:  rmux = isr;
      OFF_BDH:  rmux = BAUD_HI;
      OFF_BDL:  rmux = BAUD_LO;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode0       <= '0;
      mode1       <= '0;
      ptr         <= 1'b0;
      hold        <= '0;
      imr         <= '0;
      tx_en       <= 1'b0;
      tx_empty    <= 1'b1;
      rx_en       <= 1'b0;
      brk         <= 1'b0;
      bus_rdata_o <= '0;
      tx_send_o   <= 1'b0;
      tx_byte_o   <= '0;
      rx_pop_o    <= 1'b0;
      rx_flush_o  <= 1'b0;
    end else begin
      mode0       <= n_mode0;
      mode1       <= n_mode1;
      ptr         <= n_ptr;
      hold        <= n_hold;
      imr         <= n_imr;
      tx_en       <= n_tx_en;
      tx_empty    <= n_tx_empty;
      rx_en       <= n_rx_en;
      brk         <= n_brk;
      bus_rdata_o <= rd ? rmux : '0;
      tx_send_o   <= send;
      if (send) tx_byte_o <= n_hold;
      rx_pop_o    <= rd && bus_addr_i == OFF_DATA && rx_nonempty_i;
      rx_flush_o  <= flush;
    end
  end

endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel_i,
  input logic       bus_we_i,
  input logic [5:0] bus_addr_i,
  input logic       irq_o,
  input logic [7:0] imr,
  input logic       tx_en,
  input logic       tx_empty,
  input logic       tx_send_o,
  input logic       rx_pop_o,
  input logic       rx_nonempty_i,
  input logic       brk,
  input logic       break_i,
  input logic       ptr
);

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 8'h00) |-> !irq_o);

  // R4
  enabled_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> tx_empty);

  // R4
  send_leaves_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send_o |-> tx_empty);

  // R9
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_o |-> $past(rx_nonempty_i));

  // R8
  brk_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> $past(break_i));

  // R2
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_we_i && bus_addr_i == 6'h00) |=> ptr);

endmodule

bind uart_regblock uart_regblock_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel_i     (bus_sel_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .irq_o         (irq_o),
  .imr           (imr),
  .tx_en         (tx_en),
  .tx_empty      (tx_empty),
  .tx_send_o     (tx_send_o),
  .rx_pop_o      (rx_pop_o),
  .rx_nonempty_i (rx_nonempty_i),
  .brk           (brk),
  .break_i       (break_i),
  .ptr           (ptr)
);

// File: tb/uart_regblock_test.sv
`timescale 1ns/1ps
module uart_regblock_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, tx_send, rx_pop, rx_flush, rx_en;
  logic [7:0] tx_byte;
  logic       ne = 1'b0, full = 1'b0, brk_in = 1'b0;
  logic [7:0] rxd = '0;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  uart_regblock uut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq),
    .tx_send_o(tx_send), .tx_byte_o(tx_byte),
    .rx_nonempty_i(ne), .rx_full_i(full), .rx_data_i(rxd),
    .rx_pop_o(rx_pop), .rx_flush_o(rx_flush), .rx_enable_o(rx_en),
    .break_i(brk_in)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  function automatic logic [7:0] exp_status(input logic te, input logic emp,
                                             input logic f, input logic n);
    return {4'b0, emp, te, f, n};
  endfunction

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 tx_send", {7'b0, tx_send}, 8'h00);
    chk("R1 rx_en", {7'b0, rx_en}, 8'h00);
    rd(6'h04, v); chk("R1 status", v, 8'h08);
    rd(6'h14, v); chk("R1 isr", v, 8'h00);
    rd(6'h00, v); chk("R1 mode0", v, 8'h00);
    rd(6'h00, v); chk("R1 mode0 again", v, 8'h00);

    // R2 mode pointer
    wr(6'h00, 8'hA5);
    rd(6'h00, v); chk("R2 second reg", v, 8'h00);
    wr(6'h00, 8'h3C);
    rd(6'h00, v); chk("R2 second written", v, 8'h3C);
    wr(6'h08, 8'h10);
    rd(6'h00, v); chk("R2 pointer back", v, 8'hA5);
    wr(6'h00, 8'h00);
    rd(6'h00, v); chk("R2 stays second", v, 8'h3C);
    wr(6'h08, 8'h10);
    rd(6'h00, v); chk("R2 first cleared", v, 8'h00);

    // R3 status sweep and write ignore
    for (int te = 0; te < 2; te++) begin
      wr(6'h08, te[0] ? 8'h04 : 8'h08);
      for (int k = 0; k < 3; k++) begin
        ne = (k != 0); full = (k == 2);
        rd(6'h04, v); chk("R3 status", v, exp_status(te[0], 1'b1, full, ne));
        wr(6'h04, 8'hFF);
        rd(6'h04, v); chk("R3 write ignored", v, exp_status(te[0], 1'b1, full, ne));
      end
    end
    ne = 1'b0; full = 1'b0;

    // R5 command field sweep
    begin
      logic mt, mr;
      wr(6'h08, 8'h0A);
      mt = 1'b0; mr = 1'b0;
      for (int tf = 0; tf < 4; tf++) begin
        for (int rf = 0; rf < 4; rf++) begin
          wr(6'h08, {4'b0, tf[1:0], rf[1:0]});
          if (tf == 1) mt = 1'b1;
          if (tf == 2) mt = 1'b0;
          if (rf == 1) mr = 1'b1;
          if (rf == 2) mr = 1'b0;
          chk("R5 rx enable", {7'b0, rx_en}, {7'b0, mr});
          rd(6'h04, v); chk("R5 tx enable", v, exp_status(mt, 1'b1, 1'b0, 1'b0));
        end
      end
    end

    // R4 held byte then enable
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h5A);
    chk("R4 no send while disabled", {7'b0, tx_send}, 8'h00);
    rd(6'h04, v); chk("R4 empty cleared", v, exp_status(1'b0, 1'b0, 1'b0, 1'b0));
    wr(6'h08, 8'h04);
    chk("R4 send on enable", {7'b0, tx_send}, 8'h01);
    chk("R4 held byte", tx_byte, 8'h5A);
    rd(6'h04, v); chk("R4 empty set", v, exp_status(1'b1, 1'b1, 1'b0, 1'b0));
    chk("R4 single strobe", {7'b0, tx_send}, 8'h00);
    for (int b = 0; b < 256; b++) begin
      wr(6'h0C, b[7:0]);
      chk("R4 send strobe", {7'b0, tx_send}, 8'h01);
      chk("R4 send byte", tx_byte, b[7:0]);
    end

    // R6 receiver and transmitter reset
    wr(6'h08, 8'h01);
    chk("R6 rx enabled", {7'b0, rx_en}, 8'h01);
    wr(6'h08, 8'h20);
    chk("R6 flush pulse", {7'b0, rx_flush}, 8'h01);
    chk("R6 rx disabled", {7'b0, rx_en}, 8'h00);
    rd(6'h04, v);
    chk("R6 flush one cycle", {7'b0, rx_flush}, 8'h00);
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'hC3);
    wr(6'h08, 8'h30);
    chk("R6 no send on tx reset", {7'b0, tx_send}, 8'h00);
    rd(6'h04, v); chk("R6 tx reset status", v, exp_status(1'b0, 1'b1, 1'b0, 1'b0));
    wr(6'h08, 8'h04);
    chk("R6 dropped byte not sent", {7'b0, tx_send}, 8'h00);

    // R7 interrupt sweep
    for (int rs = 0; rs < 2; rs++)
      for (int te = 0; te < 2; te++)
        for (int k = 0; k < 3; k++)
          for (int m = 0; m < 9; m++) begin
            logic [7:0] mask, ei;
            logic ri;
            mask = (m == 8) ? 8'h00 : 8'(1 << m);
            wr(6'h08, 8'h10);
            wr(6'h00, rs[0] ? 8'h40 : 8'h00);
            wr(6'h08, te[0] ? 8'h04 : 8'h08);
            wr(6'h14, mask);
            ne = (k != 0); full = (k == 2);
            ri = rs[0] ? full : ne;
            ei = {5'b0, 1'b0, ri, te[0]};
            rd(6'h14, v); chk("R7 isr", v, ei);
            chk("R7 irq", {7'b0, irq}, {7'b0, |(ei & mask)});
          end
    ne = 1'b0; full = 1'b0;

    // R11 mask not read back
    wr(6'h08, 8'h08);
    wr(6'h14, 8'hFF);
    rd(6'h14, v); chk("R11 isr not mask", v, 8'h00);
    chk("R11 irq low", {7'b0, irq}, 8'h00);

    // R8 break sticky
    @(negedge clk); brk_in = 1'b1;
    @(negedge clk); brk_in = 1'b0;
    rd(6'h14, v); chk("R8 brk set", v, 8'h04);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    wr(6'h08, 8'h40);
    rd(6'h14, v); chk("R8 brk held", v, 8'h04);
    wr(6'h08, 8'h50);
    rd(6'h14, v); chk("R8 brk cleared", v, 8'h00);
    chk("R8 irq cleared", {7'b0, irq}, 8'h00);

    // R9 receive reads
    ne = 1'b1; rxd = 8'h96;
    rd(6'h0C, v); chk("R9 rx data", v, 8'h96);
    chk("R9 pop", {7'b0, rx_pop}, 8'h01);
    @(negedge clk);
    chk("R9 pop one cycle", {7'b0, rx_pop}, 8'h00);
    ne = 1'b0;
    rd(6'h0C, v); chk("R9 empty read", v, 8'h00);
    chk("R9 no pop", {7'b0, rx_pop}, 8'h00);

    // R10 baud bytes and unmapped offsets
    for (int a = 0; a < 64; a++) begin
      logic [7:0] e;
      if (a == 8'h00 || a == 8'h04 || a == 8'h0C || a == 8'h14) continue;
      e = (a == 8'h18) ? 8'h00 : (a == 8'h1C) ? 8'h1A : 8'h00;
      rd(a[5:0], v); chk("R10 read map", v, e);
    end
    @(negedge clk);
    chk("R10 idle rdata", rdata, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule